// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block resolves a missed address translation by reading a two-level page table held in physical memory. A requester presents a virtual page number together with the page number of the current first-level table. The walker reads the first-level entry, follows it to a second-level table, and reads the second-level entry. Those reads go out one at a time on a plain request/response port. Every address the walker emits is physical and is never translated again.

The walk ends in one of two ways. It may produce a one-cycle refill result that carries the physical page number and the three permission bits, ready to be written into a translation cache. Otherwise it produces a one-cycle page-fault pulse that names the level holding the non-present entry. The walker never retries. The first non-present entry at either level ends the walk. A start that arrives while a walk is running is dropped.

The virtual address is 32 bits wide. Its upper 10 bits index the first-level table, the next 10 bits index the second-level table, and the low 12 bits are the page offset. A page table entry (PTE) is 32 bits wide. Bit 0 is the present flag, bits 3:1 hold the permissions (bit 1 read, bit 2 write, bit 3 user) and bits 31:12 hold a physical page number.

Top module: `pgwalk`

## Requirements
- R1: During and right after reset, memReqValid, walkBusy, refillValid and faultValid are all 0.
- R2: A start accepted while idle makes memReqValid high for exactly one cycle. That cycle is the one after the start edge, and in it memReqAddr = {rootPpn, startVpn[19:10], 2'b00}.
- R3: At most one read is outstanding. A new request is issued only after the response to the previous one. A response that arrives while no read is pending has no effect, so no request appears and walkBusy stays low.
- R4: When the first-level PTE has bit 0 = 1, the next request uses memReqAddr = {PTE[31:12], VPN[9:0], 2'b00}. That request is issued in the cycle after the response.
- R5: When the first-level PTE has bit 0 = 0, the walker issues no second read. It pulses faultValid with faultLevel = 0.
- R6: When the second-level PTE has bit 0 = 0, the walker pulses faultValid with faultLevel = 1.
- R7: When the second-level PTE has bit 0 = 1, the walker pulses refillValid with refillPpn = PTE[31:12] and refillPerm = PTE[3:1].
- R8: refillValid and faultValid are never high together. Each is high for exactly one cycle, and the walker is idle in the following cycle.
- R9: A start presented while walkBusy is high, including the cycle of the result pulse, is ignored. The walk in progress keeps its original VPN and root, and no extra walk follows.
- R10: walkBusy is high from the cycle after an accepted start up to and including the result pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| startValid | input | 1 | Request to walk for startVpn |
| startVpn | input | 20 | Virtual page number that missed |
| rootPpn | input | 20 | Page number of the first-level table |
| memReqValid | output | 1 | One-cycle read request |
| memReqAddr | output | 32 | Physical byte address of the PTE |
| memRspValid | input | 1 | Read data is valid |
| memRspData | input | 32 | PTE read from memory |
| walkBusy | output | 1 | A walk is in progress |
| refillValid | output | 1 | One-cycle successful translation |
| refillPpn | output | 20 | Resolved physical page number |
| refillPerm | output | 3 | Permissions {user, write, read} |
| faultValid | output | 1 | One-cycle page fault |
| faultLevel | output | 1 | 0 = first-level entry absent, 1 = second-level |

## Verification
The bench targets entries whose present bit is clear while their other bits are set. A walker that decoded the wrong bit would then refill instead of faulting, or would issue a second read after a first-level fault. The bench also uses all-ones and all-zero VPNs and roots. A mis-sliced index or a missing two-bit scale would show up there as a wrong request address. It sends starts in the middle of a walk and in the cycle of the result pulse, where a walker that accepted them would emit stray requests. It also sends an unsolicited response while idle, which a walker that did not check its state would treat as a PTE. Response latency varies from one to four cycles, which exposes a walker that samples data at a fixed delay.

// File: rtl/pgwalk_pkg.sv
package pgwalk_pkg;

  typedef enum logic [2:0] {
    WS_IDLE,
    WS_L1_REQ,
    WS_L1_WAIT,
    WS_L2_REQ,
    WS_L2_WAIT,
    WS_DONE,
    WS_FAULT
  } walkState_e;

  // strobes from control to datapath
  typedef struct packed {
    logic loadStart;  // capture VPN and root
    logic loadNext;   // first-level PTE gives next table base
    logic loadLeaf;   // second-level PTE gives result
    logic selLevel2;  // address uses second-level index
    logic setFault;   // record fault level
    logic faultL2;    // level to record
  } walkStrobe_t;

endpackage

// File: rtl/pgwalk_ctrl.sv
module pgwalk_ctrl
  import pgwalk_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        startValid,
  input  logic        rspValid,
  input  logic        ptePresent,
  output walkStrobe_t st,
  output logic        reqValid,
  output logic        doneValid,
  output logic        faultValid,
  output logic        busy
);

  walkState_e stateQ, stateD;

  always_ff @(posedge clk) begin
    if (!rstN) stateQ <= WS_IDLE;
    else       stateQ <= stateD;
  end

  always_comb begin
    stateD     = stateQ;
    st         = '0;
    reqValid   = 1'b0;
    doneValid  = 1'b0;
    faultValid = 1'b0;
    unique case (stateQ)
      WS_IDLE: begin
        if (startValid) begin
          st.loadStart = 1'b1;
          stateD       = WS_L1_REQ;
        end
      end
      WS_L1_REQ: begin
        reqValid = 1'b1;
        stateD   = WS_L1_WAIT;
      end
      WS_L1_WAIT: begin
        if (rspValid) begin
          if (ptePresent) begin
            st.loadNext = 1'b1;
            stateD      = WS_L2_REQ;
          end else begin
            st.setFault = 1'b1;
            stateD      = WS_FAULT;
          end
        end
      end
      WS_L2_REQ: begin
        reqValid     = 1'b1;
        st.selLevel2 = 1'b1;
        stateD       = WS_L2_WAIT;
      end
      WS_L2_WAIT: begin
        if (rspValid) begin
          if (ptePresent) begin
            st.loadLeaf = 1'b1;
            stateD      = WS_DONE;
          end else begin
            st.setFault = 1'b1;
            st.faultL2  = 1'b1;
            stateD      = WS_FAULT;
          end
        end
      end
      WS_DONE: begin
        doneValid = 1'b1;
        stateD    = WS_IDLE;
      end
      WS_FAULT: begin
        faultValid = 1'b1;
        stateD     = WS_IDLE;
      end
      default: stateD = WS_IDLE;
    endcase
  end

  assign busy = (stateQ != WS_IDLE);

  p_single_result_r8: assert property (@(posedge clk) disable iff (!rstN)
    !(doneValid && faultValid));

  p_result_pulse_r8: assert property (@(posedge clk) disable iff (!rstN)
    (doneValid || faultValid) |=> (!doneValid && !faultValid && !busy));

  p_req_pulse_r3: assert property (@(posedge clk) disable iff (!rstN)
    reqValid |=> !reqValid);

  p_l1_absent_r5: assert property (@(posedge clk) disable iff (!rstN)
    (stateQ == WS_L1_WAIT && rspValid && !ptePresent) |=> (faultValid && !reqValid));

  p_l2_absent_r6: assert property (@(posedge clk) disable iff (!rstN)
    (stateQ == WS_L2_WAIT && rspValid && !ptePresent) |=> faultValid);

  p_busy_after_start_r10: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && startValid) |=> (busy && reqValid));

endmodule

// File: rtl/pgwalk_dpath.sv
module pgwalk_dpath
  import pgwalk_pkg::*;
#(
  parameter int IDX_W  = 10,
  parameter int OFF_W  = 12,
  parameter int PERM_W = 3,
  localparam int VPN_W = 2 * IDX_W,
  localparam int PA_W  = VPN_W + OFF_W,
  localparam int SH_W  = OFF_W - IDX_W
)(
  input  logic              clk,
  input  logic              rstN,
  input  walkStrobe_t       st,
  input  logic [VPN_W-1:0]  startVpn,
  input  logic [VPN_W-1:0]  rootPpn,
  input  logic [PA_W-1:0]   rspData,
  output logic              ptePresent,
  output logic [PA_W-1:0]   memReqAddr,
  output logic [VPN_W-1:0]  donePpn,
  output logic [PERM_W-1:0] donePerm,
  output logic              faultLevel
);

  logic [VPN_W-1:0]  vpnQ;
  logic [VPN_W-1:0]  baseQ;
  logic [VPN_W-1:0]  leafPpnQ;
  logic [PERM_W-1:0] leafPermQ;
  logic              faultLvlQ;
  logic [IDX_W-1:0]  lvlIdx [2];
  logic [VPN_W-1:0]  rspPpn;

  // index of each level, upper level first
  for (genvar lv = 0; lv < 2; lv++) begin : g_idx
    assign lvlIdx[lv] = vpnQ[(2-lv)*IDX_W-1 -: IDX_W];
  end

  assign ptePresent = rspData[0];
  assign rspPpn     = rspData[PA_W-1 -: VPN_W];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      vpnQ      <= '0;
      baseQ     <= '0;
      leafPpnQ  <= '0;
      leafPermQ <= '0;
      faultLvlQ <= 1'b0;
    end else begin
      if (st.loadStart) begin
        vpnQ  <= startVpn;
        baseQ <= rootPpn;
      end
      if (st.loadNext) baseQ <= rspPpn;
      if (st.loadLeaf) begin
        leafPpnQ  <= rspPpn;
        leafPermQ <= rspData[PERM_W:1];
      end
      if (st.setFault) faultLvlQ <= st.faultL2;
    end
  end

  assign memReqAddr = {baseQ, lvlIdx[st.selLevel2], {SH_W{1'b0}}};
  assign donePpn    = leafPpnQ;
  assign donePerm   = leafPermQ;
  assign faultLevel = faultLvlQ;

  p_start_captures_r2: assert property (@(posedge clk) disable iff (!rstN)
    st.loadStart |=> (vpnQ == $past(startVpn) && baseQ == $past(rootPpn)));

endmodule

// File: rtl/pgwalk.sv
module pgwalk
  import pgwalk_pkg::*;
#(
  parameter int IDX_W  = 10,
  parameter int OFF_W  = 12,
  parameter int PERM_W = 3,
  localparam int VPN_W = 2 * IDX_W,
  localparam int PA_W  = VPN_W + OFF_W
)(
  input  logic              clk,
  input  logic              rstN,
  input  logic              startValid,
  input  logic [VPN_W-1:0]  startVpn,
  input  logic [VPN_W-1:0]  rootPpn,
  output logic              memReqValid,
  output logic [PA_W-1:0]   memReqAddr,
  input  logic              memRspValid,
  input  logic [PA_W-1:0]   memRspData,
  output logic              walkBusy,
  output logic              refillValid,
  output logic [VPN_W-1:0]  refillPpn,
  output logic [PERM_W-1:0] refillPerm,
  output logic              faultValid,
  output logic              faultLevel
);

  walkStrobe_t st;
  logic        ptePresent;

  pgwalk_ctrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .startValid (startValid),
    .rspValid   (memRspValid),
    .ptePresent (ptePresent),
    .st         (st),
    .reqValid   (memReqValid),
    .doneValid  (refillValid),
    .faultValid (faultValid),
    .busy       (walkBusy)
  );

  pgwalk_dpath #(
    .IDX_W  (IDX_W),
    .OFF_W  (OFF_W),
    .PERM_W (PERM_W)
  ) u_dpath (
    .clk        (clk),
    .rstN       (rstN),
    .st         (st),
    .startVpn   (startVpn),
    .rootPpn    (rootPpn),
    .rspData    (memRspData),
    .ptePresent (ptePresent),
    .memReqAddr (memReqAddr),
    .donePpn    (refillPpn),
    .donePerm   (refillPerm),
    .faultLevel (faultLevel)
  );

  p_busy_ignores_start_r9: assert property (@(posedge clk) disable iff (!rstN)
    walkBusy |-> !st.loadStart);

endmodule

// File: tb/sim_pgwalk.sv
module sim_pgwalk;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        startValid = 1'b0;
  logic [19:0] startVpn = '0;
  logic [19:0] rootPpn = '0;
  logic        memReqValid;
  logic [31:0] memReqAddr;
  logic        rspA = 1'b0;
  logic        rspB = 1'b0;
  logic        memRspValid;
  logic [31:0] memRspData = '0;
  logic        walkBusy, refillValid, faultValid, faultLevel;
  logic [19:0] refillPpn;
  logic [2:0]  refillPerm;

  assign memRspValid = rspA | rspB;

  always #(CLK_PERIOD/2) clk = ~clk;

  pgwalk u0 (
    .clk(clk), .rstN(rstN), .startValid(startValid), .startVpn(startVpn),
    .rootPpn(rootPpn), .memReqValid(memReqValid), .memReqAddr(memReqAddr),
    .memRspValid(memRspValid), .memRspData(memRspData), .walkBusy(walkBusy),
    .refillValid(refillValid), .refillPpn(refillPpn), .refillPerm(refillPerm),
    .faultValid(faultValid), .faultLevel(faultLevel)
  );

  typedef struct packed {
    logic        isFault;
    logic        lvl;
    logic [19:0] ppn;
    logic [2:0]  perm;
  } res_t;

  logic [31:0] memArr [logic [31:0]];
  logic [31:0] expAddrQ [$];
  string       expTagQ [$];
  res_t        expResQ [$];
  int          nChecks = 0;
  int          nFails = 0;
  int          rspLat = 1;
  bit          finished = 1'b0;

  task automatic check(bit ok, string req, string what, logic [31:0] act, logic [31:0] exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] readMem(logic [31:0] a);
    if (memArr.exists(a)) return memArr[a];
    return 32'h0;
  endfunction

  // memory responder and request monitor
  initial begin
    forever begin
      @(negedge clk);
      rspA = 1'b0;
      if (memReqValid) begin
        logic [31:0] a;
        a = memReqAddr;
        if (expAddrQ.size() == 0) begin
          check(1'b0, "R3", "unexpected request", a, 32'h0);
        end else begin
          logic [31:0] ea;
          string tg;
          ea = expAddrQ.pop_front();
          tg = expTagQ.pop_front();
          check(a == ea, tg, "request address", a, ea);
        end
        repeat (rspLat) @(negedge clk);
        rspA = 1'b1;
        memRspData = readMem(a);
      end
    end
  end

  // result monitor
  initial begin
    forever begin
      @(negedge clk);
      if (refillValid || faultValid) begin
        res_t e;
        check(!(refillValid && faultValid), "R8", "both results", {refillValid, faultValid}, 2'b00);
        if (expResQ.size() == 0) begin
          check(1'b0, "R9", "unexpected result", {refillValid, faultValid}, 0);
        end else begin
          e = expResQ.pop_front();
          check(faultValid == e.isFault, e.isFault ? "R5" : "R7", "result kind",
                faultValid, e.isFault);
          if (e.isFault)
            check(faultLevel == e.lvl, e.lvl ? "R6" : "R5", "fault level", faultLevel, e.lvl);
          else
            check({refillPpn, refillPerm} == {e.ppn, e.perm}, "R7", "refill ppn/perm",
                  {refillPpn, refillPerm}, {e.ppn, e.perm});
        end
        check(walkBusy, "R10", "busy during result", walkBusy, 1);
        @(negedge clk);
        check(!refillValid && !faultValid && !walkBusy, "R8", "pulse length",
              {refillValid, faultValid, walkBusy}, 0);
      end
    end
  end

  task automatic runWalk(logic [19:0] vpn, logic [19:0] root, logic [31:0] pte1,
                         logic [31:0] pte2, int lat, bit pokeBusy, bit pokeEnd);
    logic [31:0] a1, a2;
    res_t e;
    a1 = {root, vpn[19:10], 2'b00};
    a2 = {pte1[31:12], vpn[9:0], 2'b00};
    memArr[a1] = pte1;
    expAddrQ.push_back(a1); expTagQ.push_back("R2");
    if (pte1[0]) begin
      memArr[a2] = pte2;
      expAddrQ.push_back(a2); expTagQ.push_back("R4");
      e = pte2[0] ? '{1'b0, 1'b0, pte2[31:12], pte2[3:1]} : '{1'b1, 1'b1, 20'h0, 3'h0};
    end else begin
      e = '{1'b1, 1'b0, 20'h0, 3'h0};
    end
    expResQ.push_back(e);
    rspLat = lat;
    startValid = 1'b1; startVpn = vpn; rootPpn = root;
    @(negedge clk);
    startValid = 1'b0; startVpn = ~vpn; rootPpn = ~root;
    check(walkBusy && memReqValid, "R10", "busy and request after start",
          {walkBusy, memReqValid}, 2'b11);
    if (pokeBusy) begin
      repeat (2) @(negedge clk);
      startValid = 1'b1;
      @(negedge clk);
      startValid = 1'b0;
    end
    while (!(refillValid || faultValid)) @(negedge clk);
    if (pokeEnd) startValid = 1'b1;
    @(negedge clk);
    startValid = 1'b0;
    repeat (6) @(negedge clk);
    check(expAddrQ.size() == 0 && expResQ.size() == 0 && !walkBusy, "R9",
          "no leftover or extra walk", expAddrQ.size(), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(!memReqValid && !walkBusy && !refillValid && !faultValid, "R1", "reset outputs",
          {memReqValid, walkBusy, refillValid, faultValid}, 0);
    rstN = 1'b1;
    @(negedge clk);
    check(!memReqValid && !walkBusy && !refillValid && !faultValid, "R1", "after reset",
          {memReqValid, walkBusy, refillValid, faultValid}, 0);

    // R7 plain success, permissions read+user
    runWalk(20'h12345, 20'h00400, 32'h0008_8001, 32'hCAFE_B00B, 1, 0, 0);
    // R2 R4 index extremes, longer latency
    runWalk(20'hFFFFF, 20'hFFFFF, 32'h0000_0001, 32'h1357_9005, 3, 0, 0);
    runWalk(20'h00000, 20'h00000, 32'hFFFF_F00F, 32'h0ABC_D00F, 2, 0, 0);
    // R5 absent first level with other bits set
    runWalk(20'hA5A5A, 20'h00123, 32'hABCD_E00E, 32'h0, 1, 0, 0);
    // R6 absent second level
    runWalk(20'h5A5A5, 20'h00777, 32'h0044_4003, 32'h1234_5FFE, 4, 0, 0);
    // R9 start during walk and during result pulse
    runWalk(20'h3C3C3, 20'h00900, 32'h0055_5001, 32'h9876_5003, 4, 1, 1);
    runWalk(20'h0F0F0, 20'h00901, 32'h0000_0F00, 32'h0, 2, 1, 1);

    // R3 unsolicited response while idle
    memRspData = 32'hFFFF_FFFF;
    rspB = 1'b1;
    @(negedge clk);
    rspB = 1'b0;
    repeat (4) begin
      @(negedge clk);
      check(!walkBusy && !memReqValid, "R3", "stray response ignored",
            {walkBusy, memReqValid}, 0);
    end
    runWalk(20'h00401, 20'h00002, 32'h0066_6001, 32'h0001_200B, 1, 0, 0);

    finished = 1'b1;
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog: actual running expected finished");
      $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
      $finish;
    end
  end

endmodule